// File: doc/BRIEF.md
# Wait-State Acknowledge Generator

This block sits beside a 16-bit processor on an asynchronous bus and decides when each bus cycle ends. At the start of every address-strobe assertion it looks at the two highest address bits and the processor function code. From these it picks a fast or slow cycle and checks whether the access is allowed. It then drives the data-transfer acknowledge after a fixed number of clocks, or it raises a bus-error request in place of the acknowledge.

Fast cycles are acknowledged so that the processor's first acknowledge sample hits, and no wait states are added. Slow cycles hold the acknowledge back for six more clocks, and the processor adds one wait state per clock until it sees it. Cycles run by the disk DMA engine always take the fast timing. Interrupt-acknowledge (CPU-space) cycles are left to other logic. Both outputs are active low and go high again as soon as the address strobe goes inactive.

Top module: `dtack_waitgen`

## Requirements
- R1: While `rst_n` is low, `dtack_n` and `berr_n` are both high, whatever the bus inputs do.
- R2: Region `addr_hi`=00 (memory, any mode) and region 01 (fast I/O, supervisor) are fast. With a data strobe low, `dtack_n` goes low after the FAST_WAIT-th (default 2nd) rising clock edge that samples `as_n` low, and not before.
- R3: Region 10 (boot ROM, supervisor read) and region 11 (slow I/O, supervisor) are slow. `dtack_n` goes low after rising edge FAST_WAIT+SLOW_EXTRA (default 8) of the strobe, and not before.
- R4: Supervisor mode is `fc[2]`=1 (codes 101 supervisor data, 110 supervisor program). A user access (`fc[2]`=0, e.g. 001 or 010) to region 01, 10 or 11 gets no acknowledge. Instead `berr_n` goes low at the fast timing.
- R5: A write (`rw`=0) to region 10 raises bus error at the fast timing and gets no acknowledge, even in supervisor mode.
- R6: A cycle with `fc`=111 (CPU space) and `dma_cyc`=0 drives neither output low.
- R7: With `dma_cyc`=1 the cycle is acknowledged at the fast timing with no privilege, write or CPU-space check, whatever the region.
- R8: When `as_n` goes high, `dtack_n` and `berr_n` go high in the same instant, without waiting for a clock edge.
- R9: Each new falling edge of `as_n` restarts the wait count and decodes the region afresh. The previous cycle's count and class have no effect.
- R10: `dtack_n` stays high while `uds_n` and `lds_n` are both high. Once either strobe is seen low at a rising edge after the wait is over, `dtack_n` goes low after that edge.
- R11: `dtack_n` and `berr_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr_hi | input | 2 | Address bits 23:22, region select |
| fc | input | 3 | Processor function code |
| dma_cyc | input | 1 | High when the DMA engine owns the cycle |
| dtack_n | output | 1 | Data-transfer acknowledge, active low |
| berr_n | output | 1 | Bus-error request, active low |

## Verification
The checker watches every cycle for the following:
- the floor under each acknowledge (no fast acknowledge before FAST_WAIT edges, no slow one before the full slow count);
- mutual exclusion of the two outputs;
- release of both outputs while the strobe is high;
- the absence of an acknowledge for user, ROM-write, CPU-space and strobe-less accesses.

Only the bench's scenarios can show that an acknowledge actually arrives on the exact edge for each region and mode combination. The same holds for restarting a cycle with a different region, which must be decoded anew, and for a data strobe that arrives late, which must release the held acknowledge on the next edge.

// File: rtl/dtack_waitgen_pkg.sv
`timescale 1ns/1ps
package dtack_waitgen_pkg;

  typedef enum logic [1:0] {
    RGN_MEM   = 2'b00,
    RGN_IO_F  = 2'b01,
    RGN_BOOT  = 2'b10,
    RGN_IO_S  = 2'b11
  } region_e;

  localparam logic [2:0] FC_CPU_SPACE = 3'b111;

  typedef struct packed {
    logic slow;   // extra wait states required
    logic fault;  // bus error instead of acknowledge
    logic skip;   // cycle belongs to another responder
  } acc_class_t;

endpackage

// File: rtl/dtack_region_decode.sv
`timescale 1ns/1ps
module dtack_region_decode
  import dtack_waitgen_pkg::*;
(
  input  logic [1:0]  addr_hi,
  input  logic [2:0]  fc,
  input  logic        rw,
  input  logic        dma_cyc,
  output acc_class_t  cls
);

  region_e rgn;
  logic    super_mode;
  logic    cpu_space;
  logic    priv_bad;
  logic    wr_boot;

  always_comb begin
    rgn        = region_e'(addr_hi);
    super_mode = fc[2];
    cpu_space  = (fc == FC_CPU_SPACE);
    priv_bad   = !super_mode && (rgn != RGN_MEM);
    wr_boot    = (rgn == RGN_BOOT) && !rw;
    if (dma_cyc) begin
      cls.slow  = 1'b0;
      cls.fault = 1'b0;
      cls.skip  = 1'b0;
    end else begin
      cls.slow  = (rgn == RGN_BOOT) || (rgn == RGN_IO_S);
      cls.fault = priv_bad || wr_boot;
      cls.skip  = cpu_space;
    end
  end

endmodule

// File: rtl/dtack_wait_counter.sv
`timescale 1ns/1ps
module dtack_wait_counter #(
  parameter int CNT_W   = 4,
  parameter int CNT_MAX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_act,
  output logic             start,
  output logic [CNT_W-1:0] cnt_nx
);

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic             as_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;

  always_comb begin
    start  = as_act && !as_q;
    cnt_en = !as_act || start || (cnt_q != MAX_C);
    if (!as_act)          cnt_nx = '0;
    else if (start)       cnt_nx = ONE_C;
    else if (cnt_q == MAX_C) cnt_nx = cnt_q;
    else                  cnt_nx = cnt_q + ONE_C;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      as_q <= as_act;
      if (cnt_en) cnt_q <= cnt_nx;
    end
  end

endmodule

// File: rtl/dtack_ack_driver.sv
`timescale 1ns/1ps
module dtack_ack_driver
  import dtack_waitgen_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int FAST_THR = 2,
  parameter int SLOW_THR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_act,
  input  logic             ds_act,
  input  logic             start,
  input  acc_class_t       cls_in,
  input  logic [CNT_W-1:0] cnt_nx,
  output logic             dtack_n,
  output logic             berr_n
);

  localparam logic [CNT_W-1:0] FAST_C = CNT_W'(FAST_THR);
  localparam logic [CNT_W-1:0] SLOW_C = CNT_W'(SLOW_THR);

  acc_class_t cls_q, cls_nx;
  logic       dtack_q, dtack_d;
  logic       berr_q, berr_d;
  logic       fast_hit, wait_hit;

  always_comb begin
    cls_nx   = start ? cls_in : cls_q;
    fast_hit = (cnt_nx >= FAST_C);
    wait_hit = cls_nx.slow ? (cnt_nx >= SLOW_C) : fast_hit;
    dtack_d  = as_act && ds_act && !cls_nx.skip && !cls_nx.fault && wait_hit;
    berr_d   = as_act && !cls_nx.skip && cls_nx.fault && fast_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q   <= '0;
      dtack_q <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      if (start) cls_q <= cls_in;
      dtack_q <= dtack_d;
      berr_q  <= berr_d;
    end
  end

  // strobe release clears both outputs without a clock edge
  assign dtack_n = !(dtack_q && as_act);
  assign berr_n  = !(berr_q && as_act);

endmodule

// File: rtl/dtack_waitgen.sv
`timescale 1ns/1ps
module dtack_waitgen
  import dtack_waitgen_pkg::*;
#(
  parameter int FAST_WAIT  = 2,
  parameter int SLOW_EXTRA = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       as_n,
  input  logic       uds_n,
  input  logic       lds_n,
  input  logic       rw,
  input  logic [1:0] addr_hi,
  input  logic [2:0] fc,
  input  logic       dma_cyc,
  output logic       dtack_n,
  output logic       berr_n
);

  localparam int SLOW_THR = FAST_WAIT + SLOW_EXTRA;
  localparam int CNT_W    = $clog2(SLOW_THR + 1);

  logic             as_act;
  logic             ds_act;
  logic             start;
  logic [CNT_W-1:0] cnt_nx;
  acc_class_t       cls;

  assign as_act = !as_n;
  assign ds_act = !uds_n || !lds_n;

  dtack_region_decode u_dec (
    .addr_hi (addr_hi),
    .fc      (fc),
    .rw      (rw),
    .dma_cyc (dma_cyc),
    .cls     (cls)
  );

  dtack_wait_counter #(
    .CNT_W   (CNT_W),
    .CNT_MAX (SLOW_THR)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .as_act (as_act),
    .start  (start),
    .cnt_nx (cnt_nx)
  );

  dtack_ack_driver #(
    .CNT_W    (CNT_W),
    .FAST_THR (FAST_WAIT),
    .SLOW_THR (SLOW_THR)
  ) u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_act  (as_act),
    .ds_act  (ds_act),
    .start   (start),
    .cls_in  (cls),
    .cnt_nx  (cnt_nx),
    .dtack_n (dtack_n),
    .berr_n  (berr_n)
  );

endmodule

// File: rtl/dtack_waitgen_chk.sv
`timescale 1ns/1ps
module dtack_waitgen_chk #(
  parameter int FAST_WAIT  = 2,
  parameter int SLOW_EXTRA = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       as_n,
  input logic       uds_n,
  input logic       lds_n,
  input logic       rw,
  input logic [1:0] addr_hi,
  input logic [2:0] fc,
  input logic       dma_cyc,
  input logic       dtack_n,
  input logic       berr_n
);

  localparam int SLOW_THR = FAST_WAIT + SLOW_EXTRA;
  localparam int CW       = $clog2(SLOW_THR + 1);
  localparam logic [CW-1:0] LIM    = CW'(SLOW_THR);
  localparam logic [CW-1:0] FAST_L = CW'(FAST_WAIT);

  // edges already seen with the strobe low in the current cycle
  logic [CW-1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (as_n)       cyc <= '0;
    else if (cyc != LIM) cyc <= cyc + CW'(1);
  end

  p_never_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> berr_n);

  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (dtack_n && berr_n));

  p_fast_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && cyc < FAST_L) |-> (dtack_n && berr_n));

  p_slow_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !dma_cyc && addr_hi[1] && cyc < LIM) |-> dtack_n);

  p_user_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !dma_cyc && !fc[2] && (addr_hi != 2'b00)) |-> dtack_n);

  p_boot_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !dma_cyc && addr_hi == 2'b10 && !rw) |-> dtack_n);

  p_cpu_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !dma_cyc && fc == 3'b111) |-> (dtack_n && berr_n));

  p_dma_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && dma_cyc) |-> berr_n);

  p_need_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uds_n && lds_n) |-> dtack_n);

endmodule

bind dtack_waitgen dtack_waitgen_chk #(
  .FAST_WAIT  (FAST_WAIT),
  .SLOW_EXTRA (SLOW_EXTRA)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .as_n    (as_n),
  .uds_n   (uds_n),
  .lds_n   (lds_n),
  .rw      (rw),
  .addr_hi (addr_hi),
  .fc      (fc),
  .dma_cyc (dma_cyc),
  .dtack_n (dtack_n),
  .berr_n  (berr_n)
);

// File: tb/tb_dtack_waitgen.sv
`timescale 1ns/1ps
module tb_dtack_waitgen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       as_n, uds_n, lds_n, rw, dma_cyc;
  logic [1:0] addr_hi;
  logic [2:0] fc;
  logic       dtack_n, berr_n;

  int nchk  = 0;
  int nfail = 0;
  int ticks = 0;

  always #2.5 clk = ~clk;

  dtack_waitgen dut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rw(rw), .addr_hi(addr_hi), .fc(fc), .dma_cyc(dma_cyc),
    .dtack_n(dtack_n), .berr_n(berr_n)
  );

  // kind: 0 = acknowledge, 1 = bus error, 2 = no response
  // fields {region[1:0], fc[2:0], rw, dma, kind[1:0], delay[3:0]}
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    {2'b00, 3'b101, 1'b1, 1'b0, 2'd0, 4'd2},  // R2 memory, supervisor read
    {2'b00, 3'b010, 1'b0, 1'b0, 2'd0, 4'd2},  // R2 memory, user write
    {2'b01, 3'b101, 1'b0, 1'b0, 2'd0, 4'd2},  // R2 fast I/O, supervisor
    {2'b01, 3'b001, 1'b1, 1'b0, 2'd1, 4'd2},  // R4 fast I/O, user
    {2'b10, 3'b110, 1'b1, 1'b0, 2'd0, 4'd8},  // R3 boot read, supervisor
    {2'b10, 3'b101, 1'b0, 1'b0, 2'd1, 4'd2},  // R5 boot write, supervisor
    {2'b10, 3'b010, 1'b1, 1'b0, 2'd1, 4'd2},  // R4 boot, user
    {2'b11, 3'b101, 1'b1, 1'b0, 2'd0, 4'd8},  // R3 slow I/O, supervisor
    {2'b11, 3'b001, 1'b0, 1'b0, 2'd1, 4'd2},  // R4 slow I/O, user
    {2'b00, 3'b111, 1'b1, 1'b0, 2'd2, 4'd0},  // R6 CPU space
    {2'b10, 3'b111, 1'b0, 1'b0, 2'd2, 4'd0},  // R6 CPU space, boot write
    {2'b10, 3'b001, 1'b0, 1'b1, 2'd0, 4'd2},  // R7 DMA boot write
    {2'b11, 3'b000, 1'b1, 1'b1, 2'd0, 4'd2},  // R7 DMA slow I/O
    {2'b00, 3'b111, 1'b1, 1'b1, 2'd0, 4'd2}   // R7 DMA with CPU-space code
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic set_bus(input logic [1:0] rg, input logic [2:0] f,
                         input logic r, input logic d);
    addr_hi = rg; fc = f; rw = r; dma_cyc = d;
  endtask

  task automatic idle_bus();
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
  endtask

  function automatic string vec_tag(input logic [12:0] v);
    if (v[6])                              return "R7";
    if (v[5:4] == 2'd2)                    return "R6";
    if (v[5:4] == 2'd1 && v[12:11] == 2'b10 && !v[7] && v[10]) return "R5";
    if (v[5:4] == 2'd1)                    return "R4";
    if (v[3:0] == 4'd8)                    return "R3";
    return "R2";
  endfunction

  // watchdog
  always @(posedge clk) begin
    ticks++;
    if (ticks > 20000) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired at cycle %0d", ticks);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_bus();
    set_bus(2'b00, 3'b101, 1'b1, 1'b0);

    // R1: strobes active during reset must not acknowledge
    repeat (2) @(negedge clk);
    as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(dtack_n && berr_n, "R1", "outputs in reset (dtack,berr)",
        {dtack_n, berr_n}, 3);
    idle_bus();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dtack_n && berr_n, "R1", "outputs after reset (dtack,berr)",
        {dtack_n, berr_n}, 3);

    // table of region / mode vectors
    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      int kind, dly, bad, both;
      bit exp_dt, exp_be;
      v    = VEC[i];
      kind = int'(v[5:4]);
      dly  = int'(v[3:0]);
      bad  = 0;
      both = 0;
      set_bus(v[12:11], v[10:8], v[7], v[6]);
      as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
      for (int k = 1; k <= 12; k++) begin
        @(negedge clk);
        exp_dt = (kind == 0) && (k >= dly);
        exp_be = (kind == 1) && (k >= 2);
        if ((dtack_n != !exp_dt) || (berr_n != !exp_be)) bad++;
        if (!dtack_n && !berr_n) both++;
      end
      chk(bad == 0, vec_tag(v), "edges with wrong outputs", bad, 0);
      chk(both == 0, "R11", "edges with both outputs low", both, 0);
      idle_bus();
      #1;
      chk(dtack_n && berr_n, "R8", "outputs right after strobe release",
          {dtack_n, berr_n}, 3);
      @(negedge clk);
    end

    // R10: acknowledge held until a data strobe shows up
    begin
      int early;
      early = 0;
      set_bus(2'b00, 3'b101, 1'b0, 1'b0);
      as_n = 1'b0;
      for (int k = 1; k <= 10; k++) begin
        @(negedge clk);
        if (!dtack_n) early++;
      end
      chk(early == 0, "R10", "acks without a data strobe", early, 0);
      lds_n = 1'b0;
      #1;
      chk(dtack_n == 1'b1, "R10", "dtack_n before next edge", dtack_n, 1);
      @(negedge clk);
      chk(dtack_n == 1'b0, "R10", "dtack_n one edge after strobe", dtack_n, 0);
      idle_bus();
      @(negedge clk);
    end

    // R9: slow cycle aborted, then a fast region must be decoded anew
    set_bus(2'b10, 3'b110, 1'b1, 1'b0);
    as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
    repeat (4) @(negedge clk);
    idle_bus();
    @(negedge clk);
    set_bus(2'b00, 3'b110, 1'b1, 1'b0);
    as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
    @(negedge clk);
    chk(dtack_n == 1'b1, "R9", "restart, edge 1 dtack_n", dtack_n, 1);
    @(negedge clk);
    chk(dtack_n == 1'b0, "R9", "restart into memory, edge 2 dtack_n", dtack_n, 0);
    idle_bus();
    @(negedge clk);

    // R9: slow cycle restarted in the same region waits the full count again
    set_bus(2'b11, 3'b101, 1'b1, 1'b0);
    as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
    repeat (5) @(negedge clk);
    idle_bus();
    @(negedge clk);
    as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
    repeat (7) @(negedge clk);
    chk(dtack_n == 1'b1, "R9", "restarted slow cycle, edge 7 dtack_n", dtack_n, 1);
    @(negedge clk);
    chk(dtack_n == 1'b0, "R9", "restarted slow cycle, edge 8 dtack_n", dtack_n, 0);
    idle_bus();
    @(negedge clk);

    // R8: bus error cleared the moment the strobe rises
    set_bus(2'b11, 3'b010, 1'b1, 1'b0);
    as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(berr_n == 1'b0, "R4", "user slow I/O berr_n", berr_n, 0);
    idle_bus();
    #1;
    chk(berr_n == 1'b1, "R8", "berr_n after strobe release", berr_n, 1);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule